// File: doc/BRIEF.md
# Serial Instruction Register with Immediate Extension

This block holds a 32-bit instruction word that arrives one bit per enabled clock. During fetch every bit of the word moves one place toward bit 0, and the new serial bit enters at the top. Once the word is complete, the low 16-bit half holds an immediate operand. That half can be shifted out alone, least significant bit first, while the high half keeps the opcode and register fields steady for the rest of the instruction.

When the immediate half shifts, its top position is refilled from a selectable source. The source is zero for an unsigned operand, or the half's own most significant bit for a signed one. A consumer that reads the serial bit therefore sees a correctly extended operand for as many cycles as it needs.

The storage is four 8-bit stages. The two upper stages shift only during fetch. The two lower stages shift during fetch or immediate shifting. The shift enables are expected to come from the machine's phase logic.

Top module: `instr_shift_reg`

## Requirements
- R1: While `rst_n` is low, `word_q` is all zeros. The clear takes effect asynchronously, and the register leaves reset only on a clock edge after `rst_n` rises.
- R2: On a clock edge with both `fetch_en` and `imm_en` low, `word_q` keeps its value.
- R3: On a clock edge with `fetch_en` high, `ser_in` enters bit 31 and every other bit n takes the old bit n+1. Bit 15 takes the old bit 16 unchanged, with no extension.
- R4: On a clock edge with `imm_en` high and `fetch_en` low, bits 31..16 keep their value.
- R5: On such an immediate edge with `imm_signed` low, bits 14..0 take the old bits 15..1 and bit 15 becomes 0.
- R6: On such an immediate edge with `imm_signed` high, bits 14..0 take the old bits 15..1 and bit 15 keeps its old value.
- R7: With `fetch_en` and `imm_en` both high, the edge behaves exactly as a fetch edge (R3), whatever `imm_signed` is.
- R8: `fetch_out` always equals bit 0 of `word_q`.
- R9: `imm_bit` equals bit 0 of `word_q` while `imm_en` is high and `fetch_en` is low, and is 0 otherwise.
- R10: After 16 consecutive immediate edges, the low half is 0x0000 if they were unsigned. If they were signed, every low bit equals the half's most significant bit from before the first of them, and the high half is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Serial instruction bit, enters at bit 31 during fetch |
| fetch_en | input | 1 | Fetch shift enable for the whole word (has priority) |
| imm_en | input | 1 | Immediate shift enable for the low half |
| imm_signed | input | 1 | 1: refill the immediate top bit with its sign; 0: refill with zero |
| word_q | output | 32 | Parallel instruction word |
| imm_bit | output | 1 | Serial immediate bit, qualified by immediate shifting |
| fetch_out | output | 1 | Serial bit leaving bit 0 |

## Verification
Words with the immediate sign bit set and clear are loaded by fetch. Each is then drained with both refill settings. This separates zero fill from sign refill and shows the high half stays frozen while the low half empties. Runs with both enables raised, including with the signed select active, show that fetch wins over immediate shifting. A long pseudo-random mix of hold, fetch and immediate cycles exercises every mode transition against a behavioural model, and a reset in mid-run shows the asynchronous clear.

// File: rtl/isr_pkg.sv
package isr_pkg;
  typedef enum logic [1:0] {
    SH_HOLD  = 2'd0,
    SH_FETCH = 2'd1,
    SH_IMM   = 2'd2
  } sh_mode_e;
endpackage

// File: rtl/isr_stage.sv
module isr_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         sin,
  output logic [W-1:0] q,
  output logic         sout
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (en) q_nxt = {sin, q[W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  assign sout = q[0];
endmodule

// File: rtl/isr_mode_dec.sv
module isr_mode_dec
  import isr_pkg::*;
(
  input  logic     fetch_en,
  input  logic     imm_en,
  output sh_mode_e mode,
  output logic     upper_en,
  output logic     lower_en,
  output logic     imm_active
);
  always_comb begin
    if (fetch_en)    mode = SH_FETCH;
    else if (imm_en) mode = SH_IMM;
    else             mode = SH_HOLD;
  end

  assign upper_en   = (mode == SH_FETCH);
  assign lower_en   = (mode == SH_FETCH) || (mode == SH_IMM);
  assign imm_active = (mode == SH_IMM);
endmodule

// File: rtl/isr_fill.sv
module isr_fill (
  input  logic imm_signed,
  input  logic field_msb,
  output logic fill
);
  assign fill = imm_signed ? field_msb : 1'b0;
endmodule

// File: rtl/instr_shift_reg.sv
module instr_shift_reg
  import isr_pkg::*;
#(
  parameter int STAGE_W    = 8,
  parameter int N_STAGES   = 4,
  parameter int IMM_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ser_in,
  input  logic                          fetch_en,
  input  logic                          imm_en,
  input  logic                          imm_signed,
  output logic [STAGE_W*N_STAGES-1:0]   word_q,
  output logic                          imm_bit,
  output logic                          fetch_out
);
  localparam int WORD_W = STAGE_W * N_STAGES;
  localparam int IMM_W  = STAGE_W * IMM_STAGES;

  sh_mode_e              mode;
  logic                  upper_en;
  logic                  lower_en;
  logic                  imm_active;
  logic                  fill;
  logic [N_STAGES-1:0]   stage_en;
  logic [N_STAGES-1:0]   stage_sin;
  logic [N_STAGES-1:0]   stage_sout;

  isr_mode_dec u_dec (
    .fetch_en   (fetch_en),
    .imm_en     (imm_en),
    .mode       (mode),
    .upper_en   (upper_en),
    .lower_en   (lower_en),
    .imm_active (imm_active)
  );

  isr_fill u_fill (
    .imm_signed (imm_signed),
    .field_msb  (word_q[IMM_W-1]),
    .fill       (fill)
  );

  for (genvar g = 0; g < N_STAGES; g++) begin : g_stage
    if (g >= IMM_STAGES) begin : g_upper
      assign stage_en[g] = upper_en;
    end else begin : g_lower
      assign stage_en[g] = lower_en;
    end

    if (g == N_STAGES - 1) begin : g_top_in
      assign stage_sin[g] = ser_in;
    end else if (g == IMM_STAGES - 1) begin : g_imm_top_in
      assign stage_sin[g] = (mode == SH_FETCH) ? stage_sout[g+1] : fill;
    end else begin : g_chain_in
      assign stage_sin[g] = stage_sout[g+1];
    end

    isr_stage #(.W(STAGE_W)) u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (stage_en[g]),
      .sin   (stage_sin[g]),
      .q     (word_q[g*STAGE_W +: STAGE_W]),
      .sout  (stage_sout[g])
    );
  end

  assign fetch_out = stage_sout[0];
  assign imm_bit   = imm_active & stage_sout[0];
endmodule

// File: rtl/isr_checker.sv
module isr_checker #(
  parameter int WORD_W = 32,
  parameter int IMM_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ser_in,
  input logic              fetch_en,
  input logic              imm_en,
  input logic              imm_signed,
  input logic [WORD_W-1:0] word_q
);
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_en && !imm_en) |=> $stable(word_q));

  p_fetch_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_en |=> (word_q == {$past(ser_in), $past(word_q[WORD_W-1:1])}));

  p_upper_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_en |=> $stable(word_q[WORD_W-1:IMM_W]));

  p_imm_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (imm_en && !fetch_en) |=> (word_q[IMM_W-2:0] == $past(word_q[IMM_W-1:1])));

  p_zero_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (imm_en && !fetch_en && !imm_signed) |=> !word_q[IMM_W-1]);

  p_sign_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (imm_en && !fetch_en && imm_signed) |=> $stable(word_q[IMM_W-1]));

  p_fetch_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_en && imm_en) |=> (word_q[IMM_W-1] == $past(word_q[IMM_W])));
endmodule

bind instr_shift_reg isr_checker #(.WORD_W(WORD_W), .IMM_W(IMM_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ser_in     (ser_in),
  .fetch_en   (fetch_en),
  .imm_en     (imm_en),
  .imm_signed (imm_signed),
  .word_q     (word_q)
);

// File: tb/sim_instr_shift_reg.sv
module sim_instr_shift_reg;
  localparam int W = 32;
  localparam int H = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst_n, ser_in, fetch_en, imm_en, imm_signed;
  logic [W-1:0] word_q;
  logic         imm_bit, fetch_out;

  int n_run  = 0;
  int n_fail = 0;
  bit lo[$];
  bit hi[$];

  instr_shift_reg u0 (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .fetch_en(fetch_en),
    .imm_en(imm_en), .imm_signed(imm_signed), .word_q(word_q),
    .imm_bit(imm_bit), .fetch_out(fetch_out)
  );

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] model_word();
    logic [W-1:0] v = '0;
    for (int k = 0; k < H; k++) begin
      v[k]   = lo[k];
      v[H+k] = hi[k];
    end
    return v;
  endfunction

  task automatic model_clear();
    lo.delete();
    hi.delete();
    for (int k = 0; k < H; k++) begin
      lo.push_back(1'b0);
      hi.push_back(1'b0);
    end
  endtask

  task automatic model_clock(bit f, bit i, bit s, bit d);
    bit fb;
    if (f) begin
      lo.push_back(hi[0]);
      void'(lo.pop_front());
      void'(hi.pop_front());
      hi.push_back(d);
    end else if (i) begin
      fb = s ? lo[H-1] : 1'b0;
      void'(lo.pop_front());
      lo.push_back(fb);
    end
  endtask

  task automatic step(bit f, bit i, bit s, bit d);
    logic [W-1:0] exp;
    string        tag;
    fetch_en = f; imm_en = i; imm_signed = s; ser_in = d;
    @(posedge clk);
    model_clock(f, i, s, d);
    @(negedge clk);
    exp = model_word();
    if (f && i)  tag = "R7";
    else if (f)  tag = "R3";
    else if (i)  tag = s ? "R6" : "R5";
    else         tag = "R2";
    check((i && !f) ? "R4" : tag, {16'h0, word_q[W-1:H]}, {16'h0, exp[W-1:H]});
    check(tag, {16'h0, word_q[H-1:0]}, {16'h0, exp[H-1:0]});
    check("R8", {31'h0, fetch_out}, {31'h0, exp[0]});
    check("R9", {31'h0, imm_bit}, {31'h0, (i && !f) ? exp[0] : 1'b0});
  endtask

  task automatic load(logic [W-1:0] v);
    for (int b = 0; b < W; b++) step(1'b1, 1'b0, 1'b0, v[b]);
    check("R3", word_q, v);
  endtask

  task automatic drain(bit s);
    for (int k = 0; k < H; k++) step(1'b0, 1'b1, s, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog all requirements: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    rst_n = 1'b0; ser_in = 1'b0; fetch_en = 1'b0; imm_en = 1'b0; imm_signed = 1'b0;
    model_clear();
    repeat (3) @(negedge clk);
    check("R1", word_q, '0);
    check("R1", {31'h0, fetch_out}, 32'h0);
    rst_n = 1'b1;

    load(32'hA5C3_F00F);
    for (int k = 0; k < 5; k++) step(1'b0, 1'b0, 1'b1, 1'b1);
    drain(1'b1);
    check("R10", word_q, 32'hA5C3_FFFF);

    load(32'h1234_8001);
    drain(1'b0);
    check("R10", word_q, 32'h1234_0000);

    load(32'h0F0F_7FFE);
    drain(1'b1);
    check("R10", word_q, 32'h0F0F_0000);

    load(32'hDEAD_BEEF);
    for (int k = 0; k < 8; k++) step(1'b1, 1'b1, 1'b1, k[0]);

    lfsr = 16'hACE1;
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] & lfsr[5], lfsr[1] | lfsr[7], lfsr[2], lfsr[3]);
    end

    rst_n = 1'b0;
    #2;
    check("R1", word_q, '0);
    model_clear();
    @(negedge clk);
    check("R1", word_q, '0);
    rst_n = 1'b1;
    load(32'h8765_4321);
    drain(1'b0);
    check("R10", word_q, 32'h8765_0000);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule